// File: doc/BRIEF.md
# Concurrent-Write Conflict Resolver

This block sits in front of one write port of a memory bank and settles what happens when several requesters try to store into the same word in the same clock cycle. Every requester offers a valid bit and a data word. A policy input decides how a collision is settled: accept only if all offered values agree, let one requester win through a rotating choice, let the best-ranked requester win, or fold all offered values together with an associative operator. The result is one registered write strobe with its data, plus a per-requester success and failure indication.

In the folding policy a sub-operation selects addition (wrapping, with an overflow flag), bitwise OR, AND, XOR or unsigned maximum. Reads of the word never collide, so the word read from the bank is fanned out unchanged to every requester without any arbitration.

Top module: `cw_resolve`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it falls, `wr_en`, `wr_data`, `wr_ok`, `wr_fail` and `sum_ovf` are all zero.
- R2: When no bit of `req_valid` is set at a clock edge, after that edge `wr_en` is 0, `wr_data` is 0, `wr_ok` and `wr_fail` are 0 and `sum_ovf` is 0.
- R3: With `mode` = 0 (agreement policy), if every active requester offers the same word, the word is written and `wr_ok` equals the active mask while `wr_fail` is 0; a single active requester always agrees.
- R4: With `mode` = 0, if any two active requesters offer different words, `wr_en` is 0 and `wr_fail` equals the active mask while `wr_ok` is 0.
- R5: With `mode` = 1 (rotating policy), exactly one active requester succeeds: the first active index found when scanning upward, with wrap-around, from a pointer. The pointer is 0 after reset and moves to one past the winner after each win in this mode; the other active requesters fail and the winner's word is written.
- R6: With `mode` = 2 (ranked policy), the active requester with the lowest index succeeds and its word is written; the other active requesters fail.
- R7: With `mode` = 3 and `red_op` = 0 (add), the sum of the active words modulo 2^DW is written, every active requester succeeds, and `sum_ovf` is 1 exactly when the true sum is 2^DW or more.
- R8: With `mode` = 3, `red_op` = 1, 2, 3 or 4 writes the bitwise OR, bitwise AND, bitwise XOR or unsigned maximum of the active words, inactive words do not take part, and `sum_ovf` stays 0; codes 5 to 7 act as add.
- R9: `rd_fanout` carries `rd_word` unchanged in every one of its NREQ slices, combinationally, in every mode.
- R10: All write-side outputs change only at a clock edge and reflect the inputs sampled at that edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Per-requester write request |
| req_data | input | NREQ*DW | Requester words, requester i in bits [i*DW +: DW] |
| mode | input | 2 | Policy: 0 agreement, 1 rotating, 2 ranked, 3 fold |
| red_op | input | 3 | Fold operation: 0 add, 1 OR, 2 AND, 3 XOR, 4 max |
| rd_word | input | DW | Word read from the bank |
| rd_fanout | output | NREQ*DW | Read word copied to every requester |
| wr_en | output | 1 | Registered write strobe to the bank |
| wr_data | output | DW | Registered resolved write word |
| wr_ok | output | NREQ | Registered per-requester success |
| wr_fail | output | NREQ | Registered per-requester failure |
| sum_ovf | output | 1 | Registered add-overflow flag |

## Verification
The hardest state to reach is the rotating pointer sitting just past the top requester or just past an index whose successors are all idle, since the pointer is internal and only moves on wins in the rotating policy. The bench walks it there through a fixed series of rotating-policy requests with chosen masks (full, full, only requester 0, upper pair, alternating), so that each step forces a wrap-around or a skip over idle requesters, and checks the winner after each. A second hard case is a carry out of the wrapped add, reached by two large words whose sum exceeds the word range while the remaining requesters are idle.

// File: rtl/cw_resolve_pkg.sv
package cw_resolve_pkg;

   typedef enum logic [1:0] {
      POL_AGREE  = 2'd0,
      POL_ROTATE = 2'd1,
      POL_RANK   = 2'd2,
      POL_FOLD   = 2'd3
   } policy_e;

   typedef enum logic [2:0] {
      FOLD_ADD = 3'd0,
      FOLD_OR  = 3'd1,
      FOLD_AND = 3'd2,
      FOLD_XOR = 3'd3,
      FOLD_MAX = 3'd4
   } fold_e;

endpackage

// File: rtl/cw_rank_pick.sv
// Fixed-rank selector: lowest index wins.
module cw_rank_pick #(
   parameter int NREQ = 4,
   localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
   input  logic [NREQ-1:0] req,
   output logic [NREQ-1:0] win,
   output logic [IW-1:0]   idx
);
   always_comb begin
      win = '0;
      idx = '0;
      for (int i = NREQ - 1; i >= 0; i--) begin
         if (req[i]) begin
            win    = '0;
            win[i] = 1'b1;
            idx    = IW'(i);
         end
      end
   end
endmodule

// File: rtl/cw_rot_pick.sv
// Rotating selector: scans upward from a pointer that moves past each winner.
module cw_rot_pick #(
   parameter int NREQ = 4,
   localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] req,
   input  logic            advance,
   output logic [NREQ-1:0] win,
   output logic [IW-1:0]   idx
);
   logic [IW-1:0] ptr_q;
   logic          found;

   always_comb begin
      win   = '0;
      idx   = '0;
      found = 1'b0;
      for (int k = 0; k < NREQ; k++) begin
         int j;
         j = (int'(ptr_q) + k) % NREQ;
         if (!found && req[j]) begin
            found  = 1'b1;
            win[j] = 1'b1;
            idx    = IW'(j);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (advance && found) begin
         if (idx == IW'(NREQ - 1)) ptr_q <= '0;
         else                      ptr_q <= idx + IW'(1);
      end
   end
endmodule

// File: rtl/cw_fold.sv
// Associative fold of the active words.
module cw_fold #(
   parameter int NREQ = 4,
   parameter int DW   = 8,
   localparam int SW  = DW + $clog2(NREQ) + 1
) (
   input  logic [NREQ-1:0]    req,
   input  logic [NREQ*DW-1:0] data,
   input  logic [2:0]         op,
   output logic [DW-1:0]      res,
   output logic               ovf
);
   import cw_resolve_pkg::*;

   logic [SW-1:0] acc_sum;
   logic [DW-1:0] acc_or, acc_and, acc_xor, acc_max, d;
   logic          is_add;

   always_comb begin
      acc_sum = '0;
      acc_or  = '0;
      acc_and = '1;
      acc_xor = '0;
      acc_max = '0;
      d       = '0;
      for (int i = 0; i < NREQ; i++) begin
         if (req[i]) begin
            d       = data[i*DW +: DW];
            acc_sum = acc_sum + SW'(d);
            acc_or  = acc_or | d;
            acc_and = acc_and & d;
            acc_xor = acc_xor ^ d;
            if (d > acc_max) acc_max = d;
         end
      end
      is_add = 1'b0;
      case (op)
         FOLD_OR:  res = acc_or;
         FOLD_AND: res = acc_and;
         FOLD_XOR: res = acc_xor;
         FOLD_MAX: res = acc_max;
         default: begin
            res    = acc_sum[DW-1:0];
            is_add = 1'b1;
         end
      endcase
      ovf = is_add && (acc_sum[SW-1:DW] != '0);
   end
endmodule

// File: rtl/cw_agree_chk.sv
// Reports whether every active word matches the reference word.
module cw_agree_chk #(
   parameter int NREQ = 4,
   parameter int DW   = 8
) (
   input  logic [NREQ-1:0]    req,
   input  logic [NREQ*DW-1:0] data,
   input  logic [DW-1:0]      ref_word,
   output logic               same
);
   logic [NREQ-1:0] diff;

   for (genvar g = 0; g < NREQ; g++) begin : g_cmp
      assign diff[g] = req[g] && (data[g*DW +: DW] != ref_word);
   end

   assign same = (diff == '0);
endmodule

// File: rtl/cw_resolve.sv
module cw_resolve #(
   parameter int NREQ = 4,
   parameter int DW   = 8,
   localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NREQ-1:0]    req_valid,
   input  logic [NREQ*DW-1:0] req_data,
   input  logic [1:0]         mode,
   input  logic [2:0]         red_op,
   input  logic [DW-1:0]      rd_word,
   output logic [NREQ*DW-1:0] rd_fanout,
   output logic               wr_en,
   output logic [DW-1:0]      wr_data,
   output logic [NREQ-1:0]    wr_ok,
   output logic [NREQ-1:0]    wr_fail,
   output logic               sum_ovf
);
   import cw_resolve_pkg::*;

   if (NREQ < 2) begin : g_bad_nreq
      $error("cw_resolve: NREQ must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("cw_resolve: DW must be at least 1");
   end

   policy_e         pol;
   logic            any_req;
   logic [NREQ-1:0] rank_win, rot_win;
   logic [IW-1:0]   rank_idx, rot_idx;
   logic [DW-1:0]   rank_word, rot_word, fold_word;
   logic            fold_ovf, agree;

   logic            nx_en, nx_ovf;
   logic [DW-1:0]   nx_data;
   logic [NREQ-1:0] nx_ok, nx_fail;

   assign pol     = policy_e'(mode);
   assign any_req = |req_valid;

   for (genvar g = 0; g < NREQ; g++) begin : g_rd
      assign rd_fanout[g*DW +: DW] = rd_word;
   end

   cw_rank_pick #(.NREQ(NREQ)) u_rank (
      .req (req_valid),
      .win (rank_win),
      .idx (rank_idx)
   );

   cw_rot_pick #(.NREQ(NREQ)) u_rot (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_valid),
      .advance (pol == POL_ROTATE),
      .win     (rot_win),
      .idx     (rot_idx)
   );

   assign rank_word = req_data[rank_idx*DW +: DW];
   assign rot_word  = req_data[rot_idx*DW +: DW];

   cw_fold #(.NREQ(NREQ), .DW(DW)) u_fold (
      .req  (req_valid),
      .data (req_data),
      .op   (red_op),
      .res  (fold_word),
      .ovf  (fold_ovf)
   );

   cw_agree_chk #(.NREQ(NREQ), .DW(DW)) u_agree (
      .req      (req_valid),
      .data     (req_data),
      .ref_word (rank_word),
      .same     (agree)
   );

   always_comb begin
      nx_en   = 1'b0;
      nx_data = '0;
      nx_ok   = '0;
      nx_fail = '0;
      nx_ovf  = 1'b0;
      if (any_req) begin
         case (pol)
            POL_AGREE: begin
               if (agree) begin
                  nx_en   = 1'b1;
                  nx_data = rank_word;
                  nx_ok   = req_valid;
               end else begin
                  nx_fail = req_valid;
               end
            end
            POL_ROTATE: begin
               nx_en   = 1'b1;
               nx_data = rot_word;
               nx_ok   = rot_win;
               nx_fail = req_valid & ~rot_win;
            end
            POL_RANK: begin
               nx_en   = 1'b1;
               nx_data = rank_word;
               nx_ok   = rank_win;
               nx_fail = req_valid & ~rank_win;
            end
            default: begin
               nx_en   = 1'b1;
               nx_data = fold_word;
               nx_ok   = req_valid;
               nx_ovf  = fold_ovf;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_data <= '0;
         wr_ok   <= '0;
         wr_fail <= '0;
         sum_ovf <= 1'b0;
      end else begin
         wr_en   <= nx_en;
         wr_data <= nx_data;
         wr_ok   <= nx_ok;
         wr_fail <= nx_fail;
         sum_ovf <= nx_ovf;
      end
   end
endmodule

// File: rtl/cw_resolve_chk.sv
module cw_resolve_chk #(
   parameter int NREQ = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NREQ-1:0] req_valid,
   input logic [1:0]      mode,
   input logic [2:0]      red_op,
   input logic            wr_en,
   input logic [NREQ-1:0] wr_ok,
   input logic [NREQ-1:0] wr_fail,
   input logic            sum_ovf
);
   logic [NREQ-1:0] v_q;
   logic [1:0]      mode_q;
   logic [2:0]      op_q;
   logic            armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q    <= '0;
         mode_q <= '0;
         op_q   <= '0;
         armed  <= 1'b0;
      end else begin
         v_q    <= req_valid;
         mode_q <= mode;
         op_q   <= red_op;
         armed  <= 1'b1;
      end
   end

   assert_ok_fail_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((wr_ok & wr_fail) == '0));

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && v_q == '0) |-> (!wr_en && wr_ok == '0 && wr_fail == '0 && !sum_ovf));

   assert_all_answered_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && v_q != '0) |-> ((wr_ok | wr_fail) == v_q));

   assert_single_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && v_q != '0 && (mode_q == 2'd1 || mode_q == 2'd2))
         |-> ($countones(wr_ok) == 1 && wr_en));

   assert_refused_all_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && mode_q == 2'd0 && v_q != '0 && !wr_en) |-> (wr_fail == v_q));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && sum_ovf) |-> (mode_q == 2'd3 && !(op_q inside {3'd1, 3'd2, 3'd3, 3'd4})));

endmodule

bind cw_resolve cw_resolve_chk #(.NREQ(NREQ)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .mode      (mode),
   .red_op    (red_op),
   .wr_en     (wr_en),
   .wr_ok     (wr_ok),
   .wr_fail   (wr_fail),
   .sum_ovf   (sum_ovf)
);

// File: tb/cw_resolve_bench.sv
module cw_resolve_bench;
   localparam int NREQ = 4;
   localparam int DW   = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NREQ-1:0]    req_valid = '0;
   logic [NREQ*DW-1:0] req_data = '0;
   logic [1:0]         mode = '0;
   logic [2:0]         red_op = '0;
   logic [DW-1:0]      rd_word = '0;
   logic [NREQ*DW-1:0] rd_fanout;
   logic               wr_en;
   logic [DW-1:0]      wr_data;
   logic [NREQ-1:0]    wr_ok, wr_fail;
   logic               sum_ovf;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   cw_resolve #(.NREQ(NREQ), .DW(DW)) u_cw_resolve (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
      .mode(mode), .red_op(red_op), .rd_word(rd_word), .rd_fanout(rd_fanout),
      .wr_en(wr_en), .wr_data(wr_data), .wr_ok(wr_ok), .wr_fail(wr_fail),
      .sum_ovf(sum_ovf)
   );

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Drive at the falling edge, let one rising edge register, sample 1 ns later.
   task automatic apply(logic [3:0] v, logic [7:0] d3, logic [7:0] d2,
                        logic [7:0] d1, logic [7:0] d0, logic [1:0] m, logic [2:0] op);
      @(negedge clk);
      req_valid = v;
      req_data  = {d3, d2, d1, d0};
      mode      = m;
      red_op    = op;
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(string tag, logic en, logic [7:0] data,
                             logic [3:0] ok, logic [3:0] fail, logic ovf);
      chk({tag, " wr_en"},   32'(wr_en),   32'(en));
      chk({tag, " wr_data"}, 32'(wr_data), 32'(data));
      chk({tag, " wr_ok"},   32'(wr_ok),   32'(ok));
      chk({tag, " wr_fail"}, 32'(wr_fail), 32'(fail));
      chk({tag, " sum_ovf"}, 32'(sum_ovf), 32'(ovf));
   endtask

   task automatic t_reset();
      req_valid = 4'b1111;
      req_data  = 32'h01020304;
      mode      = 2'd3;
      @(posedge clk);
      #1;
      expect_out("R1 reset", 1'b0, 8'h00, 4'h0, 4'h0, 1'b0);
      @(negedge clk);
      req_valid = '0;
      rst_n     = 1'b1;
   endtask

   task automatic t_idle();
      apply(4'b0000, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 2'd3, 3'd0);
      expect_out("R2 idle fold", 1'b0, 8'h00, 4'h0, 4'h0, 1'b0);
      apply(4'b0000, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 2'd1, 3'd0);
      expect_out("R2 idle rotate", 1'b0, 8'h00, 4'h0, 4'h0, 1'b0);
   endtask

   task automatic t_agree();
      apply(4'b1011, 8'h55, 8'hAA, 8'h55, 8'h55, 2'd0, 3'd0);
      expect_out("R3 agree", 1'b1, 8'h55, 4'b1011, 4'b0000, 1'b0);
      apply(4'b0100, 8'h00, 8'h9C, 8'h00, 8'h00, 2'd0, 3'd0);
      expect_out("R3 single", 1'b1, 8'h9C, 4'b0100, 4'b0000, 1'b0);
      apply(4'b0110, 8'h33, 8'h33, 8'h44, 8'h33, 2'd0, 3'd0);
      expect_out("R4 mismatch", 1'b0, 8'h00, 4'b0000, 4'b0110, 1'b0);
   endtask

   task automatic t_rotate();
      apply(4'b1111, 8'h13, 8'h12, 8'h11, 8'h10, 2'd1, 3'd0);
      expect_out("R5 step1", 1'b1, 8'h10, 4'b0001, 4'b1110, 1'b0);
      apply(4'b1111, 8'h13, 8'h12, 8'h11, 8'h10, 2'd1, 3'd0);
      expect_out("R5 step2", 1'b1, 8'h11, 4'b0010, 4'b1101, 1'b0);
      apply(4'b0001, 8'h13, 8'h12, 8'h11, 8'h10, 2'd1, 3'd0);
      expect_out("R5 wrap", 1'b1, 8'h10, 4'b0001, 4'b0000, 1'b0);
      apply(4'b1100, 8'h13, 8'h12, 8'h11, 8'h10, 2'd1, 3'd0);
      expect_out("R5 skip", 1'b1, 8'h12, 4'b0100, 4'b1000, 1'b0);
      apply(4'b1010, 8'h13, 8'h12, 8'h11, 8'h10, 2'd1, 3'd0);
      expect_out("R5 top", 1'b1, 8'h13, 4'b1000, 4'b0010, 1'b0);
      apply(4'b1010, 8'h13, 8'h12, 8'h11, 8'h10, 2'd1, 3'd0);
      expect_out("R5 after top", 1'b1, 8'h11, 4'b0010, 4'b1000, 1'b0);
   endtask

   task automatic t_rank();
      apply(4'b1100, 8'h33, 8'h22, 8'h11, 8'h00, 2'd2, 3'd0);
      expect_out("R6 upper pair", 1'b1, 8'h22, 4'b0100, 4'b1000, 1'b0);
      apply(4'b1111, 8'h33, 8'h22, 8'h11, 8'h07, 2'd2, 3'd0);
      expect_out("R6 all", 1'b1, 8'h07, 4'b0001, 4'b1110, 1'b0);
   endtask

   task automatic t_sum();
      apply(4'b1111, 8'd40, 8'd30, 8'd20, 8'd10, 2'd3, 3'd0);
      expect_out("R7 sum", 1'b1, 8'd100, 4'b1111, 4'b0000, 1'b0);
      apply(4'b0011, 8'd0, 8'd0, 8'd100, 8'd200, 2'd3, 3'd0);
      expect_out("R7 carry", 1'b1, 8'd44, 4'b0011, 4'b0000, 1'b1);
      apply(4'b0101, 8'd99, 8'd7, 8'd99, 8'd5, 2'd3, 3'd0);
      expect_out("R7 masked", 1'b1, 8'd12, 4'b0101, 4'b0000, 1'b0);
      apply(4'b0011, 8'd0, 8'd0, 8'd128, 8'd128, 2'd3, 3'd6);
      expect_out("R8 code6 adds", 1'b1, 8'd0, 4'b0011, 4'b0000, 1'b1);
   endtask

   task automatic t_subops();
      apply(4'b0111, 8'h80, 8'h04, 8'h02, 8'h01, 2'd3, 3'd1);
      expect_out("R8 or", 1'b1, 8'h07, 4'b0111, 4'b0000, 1'b0);
      apply(4'b1011, 8'hFF, 8'h00, 8'h3C, 8'hF0, 2'd3, 3'd2);
      expect_out("R8 and", 1'b1, 8'h30, 4'b1011, 4'b0000, 1'b0);
      apply(4'b1111, 8'h11, 8'hFF, 8'hF0, 8'h0F, 2'd3, 3'd3);
      expect_out("R8 xor", 1'b1, 8'h11, 4'b1111, 4'b0000, 1'b0);
      apply(4'b1110, 8'h7F, 8'h80, 8'h10, 8'hFE, 2'd3, 3'd4);
      expect_out("R8 max", 1'b1, 8'h80, 4'b1110, 4'b0000, 1'b0);
   endtask

   task automatic t_read();
      @(negedge clk);
      rd_word = 8'hA5;
      mode    = 2'd1;
      #1;
      chk("R9 fanout", rd_fanout, 32'hA5A5A5A5);
      rd_word = 8'h3C;
      mode    = 2'd3;
      #1;
      chk("R9 fanout change", rd_fanout, 32'h3C3C3C3C);
   endtask

   task automatic t_latency();
      apply(4'b0000, 8'h00, 8'h00, 8'h00, 8'h00, 2'd2, 3'd0);
      @(negedge clk);
      req_valid = 4'b0010;
      req_data  = 32'h00006600;
      mode      = 2'd2;
      #1;
      chk("R10 before edge", 32'(wr_en), 32'd0);
      @(posedge clk);
      #1;
      chk("R10 after edge", 32'(wr_data), 32'h66);
      chk("R10 after edge ok", 32'(wr_ok), 32'b0010);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_idle();
      t_agree();
      t_rotate();
      t_rank();
      t_sum();
      t_subops();
      t_read();
      t_latency();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule